// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block surrounds a single embedded core and chooses where the core's terminals connect. In functional operation the core exchanges data with the surrounding system logic as if the wrapper were absent. In test operation the core's terminals are cut off from that logic and joined to a narrow test access bus. Stimuli reach the core, or the interconnect beyond it, through that bus, and responses return along the same path. Boundary cells are grouped into one shift lane per bus bit. This lets a bus only a few bits wide serve a core with many more terminals.

A 3-bit mode register is loaded serially through its own instruction input and takes effect on the update strobe. The five modes are functional, core-internal test, interconnect test, bypass and safe. In bypass, each bus lane passes through a single flop, so several wrappers can share one rail and only the cores under test add scan length. For test purposes the core is modelled as a registered XOR function.

Top module: `cwrap_top`

## Requirements
- R1: After reset the mode is functional (code 0), every shift, update and bypass register is zero, and `tam_out` is zero.
- R2: Mode codes are functional=0, internal test=1, interconnect test=2, bypass=3, safe=4. While `instr_shift` is high, each clock shifts `instr_si` into a 3-bit register from the top end, so the least significant bit is sent first. A cycle with `update_en` high makes that code the active mode.
- R3: If the instruction register holds code 5, 6 or 7 when `update_en` is high, the active mode does not change.
- R4: In functional and bypass modes, the core receives `sys_in`. One clock later, `sys_out[j]` equals `sys_in[j mod NUM_IN] ^ sys_in[(j+1) mod NUM_IN]`.
- R5: Boundary cells are numbered as follows: core inputs take cells 0..NUM_IN-1, core outputs take the next NUM_OUT cells, and any remaining cells pad the total to TAM_W*L, where L=ceil((NUM_IN+NUM_OUT)/TAM_W). Lane c holds cells c*L..c*L+L-1. In the two test modes, each `shift_en` clock shifts `tam_in[c]` into cell c*L+L-1 and moves every cell down by one. `tam_out[c]` always shows cell c*L.
- R6: Update registers load from the shift cells only on an `update_en` clock, and only in the two test modes. Shifting leaves the core inputs and `sys_out` unchanged.
- R7: In internal test mode, the core inputs come from the input-cell update registers and `sys_out` is held at SAFE_VAL. On `capture_en`, the output cells load the core outputs and all other cells keep their values.
- R8: In interconnect test mode, `sys_out` shows the output-cell update registers. On `capture_en`, the input cells load `sys_in` and all other cells keep their values.
- R9: In bypass mode, `tam_out[c]` equals `tam_in[c]` from one clock earlier, and the boundary cells are left unchanged.
- R10: In safe mode, `sys_out` is SAFE_VAL, `tam_out` is zero, and shift, capture and data update do nothing.
- R11: In functional mode, `tam_out` is zero, and shift, capture and data update leave the boundary cells unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_in | input | NUM_IN | System logic driving the core's input terminals |
| sys_out | output | NUM_OUT | Core output terminals driving system logic |
| tam_in | input | TAM_W | Test bus data in, one bit per lane |
| tam_out | output | TAM_W | Test bus data out, one bit per lane |
| instr_si | input | 1 | Serial data into the mode instruction register |
| instr_shift | input | 1 | Shift enable for the instruction register |
| shift_en | input | 1 | Boundary lane shift strobe |
| capture_en | input | 1 | Boundary capture strobe |
| update_en | input | 1 | Update strobe for the mode and the data registers |

## Verification
The hardest condition to reach is proving that a strobe had no effect. To do that, the boundary contents must be carried across a mode in which they cannot be seen. The bench loads a known pattern in interconnect test mode and then moves to safe, functional or bypass mode. In that mode it applies shift, capture and update strobes with random data. It then returns to a test mode without a data update and scans the cells out, so any corruption shows at the bus. Invalid instruction codes are applied from a test mode in the same way, and the bench then confirms that scanning still behaves as in that mode.

// File: rtl/cwrap_pkg.sv
package cwrap_pkg;

   typedef enum logic [2:0] {
      WM_FUNC   = 3'd0,
      WM_INTEST = 3'd1,
      WM_EXTEST = 3'd2,
      WM_BYPASS = 3'd3,
      WM_SAFE   = 3'd4
   } wmode_e;

   localparam int unsigned WM_BITS = $bits(wmode_e);
   localparam int unsigned WM_LAST = 4;

endpackage

// File: rtl/cwrap_ir.sv
module cwrap_ir
   import cwrap_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ir_si,
   input  logic   ir_shift,
   input  logic   commit,
   output wmode_e mode_q
);

   logic [WM_BITS-1:0] ir_sh;
   logic               code_ok;

   assign code_ok = (ir_sh <= WM_BITS'(WM_LAST));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir_sh  <= '0;
         mode_q <= WM_FUNC;
      end else begin
         if (ir_shift) begin
            ir_sh <= {ir_si, ir_sh[WM_BITS-1:1]};
         end
         if (commit && code_ok) begin
            mode_q <= wmode_e'(ir_sh);
         end
      end
   end

   // R3: an unused code leaves the active mode alone
   p_bad_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (ir_sh > WM_BITS'(WM_LAST))) |=> $stable(mode_q));

   // R2: the mode only moves on an update strobe
   p_mode_on_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(mode_q));

endmodule

// File: rtl/cwrap_core.sv
module cwrap_core #(
   parameter int unsigned NUM_IN  = 8,
   parameter int unsigned NUM_OUT = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IN-1:0]  d,
   output logic [NUM_OUT-1:0] q
);

   logic [NUM_OUT-1:0] nxt;

   for (genvar j = 0; j < NUM_OUT; j++) begin : g_fn
      assign nxt[j] = d[j % NUM_IN] ^ d[(j + 1) % NUM_IN];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/cwrap_lane.sv
module cwrap_lane #(
   parameter int unsigned LEN = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           si,
   input  logic           shift_en,
   input  logic           cap_en,
   input  logic [LEN-1:0] cap_mask,
   input  logic [LEN-1:0] cap_data,
   input  logic           upd_en,
   input  logic           byp_en,
   output logic [LEN-1:0] upd_q,
   output logic           sh_lsb,
   output logic           byp_q
);

   logic [LEN-1:0] sh;
   logic [LEN-1:0] sh_shifted;

   if (LEN == 1) begin : g_single
      assign sh_shifted = si;
   end else begin : g_multi
      assign sh_shifted = {si, sh[LEN-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (shift_en) begin
         sh <= sh_shifted;
      end else if (cap_en) begin
         sh <= (sh & ~cap_mask) | (cap_data & cap_mask);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      upd_q <= '0;
      else if (upd_en) upd_q <= sh;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      byp_q <= 1'b0;
      else if (byp_en) byp_q <= si;
   end

   assign sh_lsb = sh[0];

   // R6: no ripple into the update stage while shifting
   p_upd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(upd_q));

   // R7: a capture touches only the selected cells
   p_cap_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !shift_en) |=> ((sh & ~$past(cap_mask)) == ($past(sh) & ~$past(cap_mask))));

   // R11: cells sit still when no strobe is qualified
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en && !shift_en) |=> $stable(sh));

endmodule

// File: rtl/cwrap_top.sv
module cwrap_top
   import cwrap_pkg::*;
#(
   parameter int unsigned        NUM_IN   = 8,
   parameter int unsigned        NUM_OUT  = 6,
   parameter int unsigned        TAM_W    = 3,
   parameter logic [NUM_OUT-1:0] SAFE_VAL = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IN-1:0]  sys_in,
   output logic [NUM_OUT-1:0] sys_out,
   input  logic [TAM_W-1:0]   tam_in,
   output logic [TAM_W-1:0]   tam_out,
   input  logic               instr_si,
   input  logic               instr_shift,
   input  logic               shift_en,
   input  logic               capture_en,
   input  logic               update_en
);

   localparam int unsigned NCELL = NUM_IN + NUM_OUT;
   localparam int unsigned LEN   = (NCELL + TAM_W - 1) / TAM_W;
   localparam int unsigned NPAD  = TAM_W * LEN;

   if (NUM_IN < 2) begin : g_chk_in
      $error("cwrap_top: NUM_IN must be at least 2");
   end
   if (NUM_OUT < 1) begin : g_chk_out
      $error("cwrap_top: NUM_OUT must be at least 1");
   end
   if (TAM_W < 1 || TAM_W > NCELL) begin : g_chk_w
      $error("cwrap_top: TAM_W must lie between 1 and the terminal count");
   end

   wmode_e             mode_q;
   logic               is_int, is_ext, is_tst, is_byp;
   logic [NPAD-1:0]    cap_mask, cap_data, upd_all;
   logic [TAM_W-1:0]   lane_lsb, lane_byp;
   logic [NUM_IN-1:0]  core_in;
   logic [NUM_OUT-1:0] core_q;

   cwrap_ir u_ir (
      .clk      (clk),
      .rst_n    (rst_n),
      .ir_si    (instr_si),
      .ir_shift (instr_shift),
      .commit   (update_en),
      .mode_q   (mode_q)
   );

   assign is_int = (mode_q == WM_INTEST);
   assign is_ext = (mode_q == WM_EXTEST);
   assign is_tst = is_int | is_ext;
   assign is_byp = (mode_q == WM_BYPASS);

   for (genvar k = 0; k < NPAD; k++) begin : g_cell
      if (k < NUM_IN) begin : g_in
         assign cap_data[k] = sys_in[k];
         assign cap_mask[k] = is_ext;
      end else if (k < NCELL) begin : g_out
         assign cap_data[k] = core_q[k - NUM_IN];
         assign cap_mask[k] = is_int;
      end else begin : g_pad
         assign cap_data[k] = 1'b0;
         assign cap_mask[k] = 1'b0;
      end
   end

   if (NPAD > NCELL) begin : g_pad_sink
      logic unused_pad;
      assign unused_pad = ^upd_all[NPAD-1:NCELL];
   end

   for (genvar c = 0; c < TAM_W; c++) begin : g_lane
      cwrap_lane #(.LEN(LEN)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .si       (tam_in[c]),
         .shift_en (shift_en & is_tst),
         .cap_en   (capture_en & is_tst),
         .cap_mask (cap_mask[c*LEN +: LEN]),
         .cap_data (cap_data[c*LEN +: LEN]),
         .upd_en   (update_en & is_tst),
         .byp_en   (is_byp),
         .upd_q    (upd_all[c*LEN +: LEN]),
         .sh_lsb   (lane_lsb[c]),
         .byp_q    (lane_byp[c])
      );
   end

   assign core_in = is_tst ? upd_all[NUM_IN-1:0] : sys_in;

   cwrap_core #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (core_in),
      .q     (core_q)
   );

   always_comb begin
      unique case (mode_q)
         WM_FUNC, WM_BYPASS: sys_out = core_q;
         WM_EXTEST:          sys_out = upd_all[NCELL-1:NUM_IN];
         default:            sys_out = SAFE_VAL;
      endcase
   end

   always_comb begin
      unique case (mode_q)
         WM_INTEST, WM_EXTEST: tam_out = lane_lsb;
         WM_BYPASS:            tam_out = lane_byp;
         default:              tam_out = '0;
      endcase
   end

   // R7: neighbours see the safe pattern while the core is under test
   p_intest_isolate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_int |-> (sys_out == SAFE_VAL));

   // R10: safe mode pins the outputs and silences the bus
   p_safe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == WM_SAFE) |-> ((sys_out == SAFE_VAL) && (tam_out == '0)));

   // R9: single-flop bypass per lane
   p_bypass_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_byp && $past(is_byp)) |-> (tam_out == $past(tam_in)));

   // R11: the bus stays quiet in functional mode
   p_func_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == WM_FUNC) |-> (tam_out == '0));

endmodule

// File: tb/cwrap_top_bench.sv
`timescale 1ns/1ps
module cwrap_top_bench;

   localparam int unsigned NI = 8;
   localparam int unsigned NO = 6;
   localparam int unsigned W  = 3;
   localparam int unsigned N  = NI + NO;
   localparam int unsigned L  = (N + W - 1) / W;
   localparam int unsigned NP = W * L;
   localparam logic [NO-1:0] SAFE = 6'b100101;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] sys_in = '0;
   logic [NO-1:0] sys_out;
   logic [W-1:0]  tam_in = '0;
   logic [W-1:0]  tam_out;
   logic          instr_si = 1'b0, instr_shift = 1'b0;
   logic          shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [NP-1:0] m_sh = '0;
   logic [NP-1:0] m_upd = '0;
   int            m_mode = 0;

   always #2.5 clk = ~clk;

   cwrap_top #(.NUM_IN(NI), .NUM_OUT(NO), .TAM_W(W), .SAFE_VAL(SAFE)) u_cwrap_top (
      .clk(clk), .rst_n(rst_n), .sys_in(sys_in), .sys_out(sys_out),
      .tam_in(tam_in), .tam_out(tam_out), .instr_si(instr_si),
      .instr_shift(instr_shift), .shift_en(shift_en),
      .capture_en(capture_en), .update_en(update_en)
   );

   function automatic logic [NO-1:0] core_fn(input logic [NI-1:0] x);
      logic [NO-1:0] r;
      for (int j = 0; j < NO; j++) r[j] = x[j % NI] ^ x[(j + 1) % NI];
      return r;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic bit in_test();
      return (m_mode == 1) || (m_mode == 2);
   endfunction

   task automatic set_mode(input logic [2:0] code);
      for (int b = 0; b < 3; b++) begin
         @(negedge clk);
         instr_si = code[b];
         instr_shift = 1'b1;
      end
      @(negedge clk);
      instr_shift = 1'b0;
      update_en = 1'b1;
      @(negedge clk);
      update_en = 1'b0;
      if (in_test()) m_upd = m_sh;
      if (code <= 3'd4) m_mode = int'(code);
   endtask

   task automatic pulse_update();
      @(negedge clk);
      update_en = 1'b1;
      @(negedge clk);
      update_en = 1'b0;
      if (in_test()) m_upd = m_sh;
   endtask

   task automatic capture();
      @(negedge clk);
      capture_en = 1'b1;
      @(negedge clk);
      capture_en = 1'b0;
      if (m_mode == 1) m_sh[N-1:NI] = core_fn(m_upd[NI-1:0]);
      else if (m_mode == 2) m_sh[NI-1:0] = sys_in;
   endtask

   // shifts vin through all lanes and checks the data coming out
   task automatic scan(input string req, input logic [NP-1:0] vin);
      logic [NP-1:0] vout;
      logic [NP-1:0] vexp;
      vexp = in_test() ? m_sh : '0;
      for (int s = 0; s < L; s++) begin
         @(negedge clk);
         for (int c = 0; c < W; c++) vout[c*L + s] = tam_out[c];
         if (m_mode == 2)
            chk("R6", "sys_out steady during shift", 64'(sys_out), 64'(m_upd[N-1:NI]));
         for (int c = 0; c < W; c++) tam_in[c] = vin[c*L + s];
         shift_en = 1'b1;
      end
      @(negedge clk);
      shift_en = 1'b0;
      tam_in = '0;
      chk(req, "scan out", 64'(vout), 64'(vexp));
      if (in_test()) m_sh = vin;
   endtask

   initial begin
      logic [NP-1:0] v;
      logic [W-1:0]  prev;
      void'($urandom(32'd4242));

      // R1: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "tam_out after reset", 64'(tam_out), 64'(0));
      chk("R1", "sys_out after reset", 64'(sys_out), 64'(0));
      set_mode(3'd2);
      @(negedge clk);
      chk("R1", "update regs cleared", 64'(sys_out), 64'(0));
      scan("R1", NP'($urandom()));

      // R4 / R11: functional mode
      set_mode(3'd0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         sys_in = NI'($urandom());
         @(negedge clk);
         chk("R4", "functional sys_out", 64'(sys_out), 64'(core_fn(sys_in)));
      end
      scan("R11", NP'($urandom()));
      capture();
      pulse_update();
      @(negedge clk);
      chk("R11", "tam_out quiet", 64'(tam_out), 64'(0));

      // R3: invalid codes from a test mode keep it
      set_mode(3'd2);
      scan("R11", NP'($urandom()));
      pulse_update();
      set_mode(3'd7);
      @(negedge clk);
      chk("R3", "code 7 keeps extest", 64'(sys_out), 64'(m_upd[N-1:NI]));
      set_mode(3'd5);
      scan("R3", NP'($urandom()));

      // R5 / R7: internal test, random plus all-ones / zero corners
      set_mode(3'd1);
      for (int i = 0; i < 12; i++) begin
         if (i == 0) v = '1;
         else if (i == 1) v = '0;
         else v = NP'($urandom());
         scan("R5", v);
         pulse_update();
         @(negedge clk);
         chk("R7", "intest isolation", 64'(sys_out), 64'(SAFE));
         capture();
      end
      scan("R7", NP'($urandom()));

      // R8: interconnect test
      set_mode(3'd2);
      for (int i = 0; i < 12; i++) begin
         scan("R8", NP'($urandom()));
         pulse_update();
         @(negedge clk);
         chk("R8", "extest drives outputs", 64'(sys_out), 64'(m_upd[N-1:NI]));
         sys_in = NI'($urandom());
         capture();
      end
      scan("R8", NP'($urandom()));

      // R9: bypass
      set_mode(3'd3);
      prev = '0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (i > 0) chk("R9", "bypass latency", 64'(tam_out), 64'(prev));
         if (i == 5) chk("R4", "bypass functional", 64'(sys_out), 64'(core_fn(sys_in)));
         tam_in = W'($urandom());
         shift_en = 1'b1;
         capture_en = (i % 3) == 0;
         prev = tam_in;
      end
      @(negedge clk);
      shift_en = 1'b0;
      capture_en = 1'b0;
      tam_in = '0;
      set_mode(3'd1);
      scan("R9", NP'($urandom()));

      // R10: safe mode ignores strobes
      set_mode(3'd2);
      scan("R10", NP'($urandom()));
      pulse_update();
      set_mode(3'd4);
      @(negedge clk);
      chk("R10", "safe outputs", 64'(sys_out), 64'(SAFE));
      chk("R10", "safe bus quiet", 64'(tam_out), 64'(0));
      sys_in = NI'($urandom());
      scan("R10", NP'($urandom()));
      capture();
      pulse_update();
      set_mode(3'd2);
      @(negedge clk);
      chk("R10", "update regs kept", 64'(sys_out), 64'(m_upd[N-1:NI]));
      scan("R10", NP'($urandom()));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog all act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule